// File: doc/BRIEF.md
# Backlight PWM Generator

The block drives a display backlight enable line with a pulse-width modulated signal derived from a fixed reference clock. A 16-bit prescaler divides the reference so that one prescaler tick occurs every (divider + 1) reference cycles. A phase counter advances once per tick and wraps after 100 ticks, so one PWM period lasts 100 × (divider + 1) reference cycles. The output is high for the first `duty` ticks of each period, with the duty code expressed directly in percent from 0 to 99.

Software or a sequencer writes four byte-wide registers through a valid/ready write port. The port never applies back-pressure: `wr_ready` is always high, and a write is accepted in every cycle where `wr_valid` is high. The divider is written as two bytes: the high byte is only staged, and writing the low byte commits both bytes together. A source-select register gates the whole generator. Divider and duty values written while the generator runs are held in pending registers and copied into the active copies only at a period boundary, so a running period is never cut short or stretched.

Top module: `bpwm_top`

## Requirements
- R1: While and after reset, `pwm_out` is 0 and `wr_ready` is 1. The source select resets to 0x00, so the generator is stopped.
- R2: The generator runs only while the source-select register (address 0) holds 0x01. For any other value, `pwm_out` is held at 0 and the phase and prescaler counters are held at zero.
- R3: While running, the period is 100 × (D + 1) reference cycles, where D is the active divider. `pwm_out` is high for exactly min(duty, 99) × (D + 1) cycles at the start of each period and low for the rest.
- R4: Duty codes above 0x63 (such as 0x64, 0x80 and 0xFF) behave as 99.
- R5: A write to the divider high byte (address 1) only stages the value. The pending divider becomes {staged high byte, written low byte} when the low byte (address 2) is written.
- R6: A duty or divider change written while the generator runs does not affect the period in progress. It applies from the next period boundary onward.
- R7: The divider resets to 1999, so a duty of 1 gives a high time of 2000 reference cycles.
- R8: A write is accepted on every cycle where `wr_valid` is 1. The registers are decoded as address 0 = source select, 1 = divider high byte, 2 = divider low byte and 3 = duty.
- R9: While stopped, written values load directly into the active registers. The first period begins with phase 0 in the cycle after the source select becomes 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Always 1; the write port never stalls |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write byte |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The hardest situation to reach is a write that lands in the middle of a running period, where the pending value must stay hidden until the boundary. This applies especially to the case where only the divider high byte has been written. The bench keeps its measurement windows aligned to period boundaries, counting from the enable cycle onward. It injects writes at a chosen offset inside a window. It then compares the high-cycle count of that window with the count of the following window, so a value that takes effect early shows up as a wrong count. Near-exhaustive duty sweeps at small divider values cover the arithmetic of R3 and R4.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  typedef enum logic [1:0] {
    SEL_SOURCE = 2'd0,
    SEL_DIV_HI = 2'd1,
    SEL_DIV_LO = 2'd2,
    SEL_DUTY   = 2'd3
  } bpwm_sel_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bpwm_regs.sv
module bpwm_regs
  import bpwm_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DIV_RESET = 1999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] source_q,
  output logic [DIV_W-1:0]  div_pend,
  output logic [BYTE_W-1:0] duty_pend
);
  localparam int unsigned HI_W = DIV_W - BYTE_W;
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

  logic [HI_W-1:0] hi_stage;
  bpwm_sel_e       sel;

  assign sel = bpwm_sel_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      source_q  <= '0;
      hi_stage  <= DIV_INIT[DIV_W-1:BYTE_W];
      div_pend  <= DIV_INIT;
      duty_pend <= '0;
    end else if (wr_fire) begin
      unique case (sel)
        SEL_SOURCE: source_q  <= wr_data;
        SEL_DIV_HI: hi_stage  <= wr_data[HI_W-1:0];
        SEL_DIV_LO: div_pend  <= {hi_stage, wr_data};
        SEL_DUTY:   duty_pend <= wr_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/bpwm_prescale.sv
module bpwm_prescale #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_act,
  output logic [DIV_W-1:0] pre_cnt,
  output logic             tick
);
  logic at_limit;

  assign at_limit = (pre_cnt == div_act);
  assign tick     = run && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (!run || at_limit) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bpwm_phase.sv
module bpwm_phase
  import bpwm_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned STEPS     = 100,
  parameter int unsigned DIV_RESET = 1999,
  parameter int unsigned PH_W      = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [DIV_W-1:0]  div_pend,
  input  logic [BYTE_W-1:0] duty_pend,
  output logic [DIV_W-1:0]  div_act,
  output logic [PH_W-1:0]   phase,
  output logic [PH_W-1:0]   duty_act,
  output logic              period_end,
  output logic              pwm_out
);
  localparam logic [PH_W-1:0]   LAST_PH  = PH_W'(STEPS - 1);
  localparam logic [BYTE_W-1:0] TOP_CODE = BYTE_W'(STEPS - 1);

  logic [PH_W-1:0] duty_lim;

  assign duty_lim   = (duty_pend > TOP_CODE) ? LAST_PH : duty_pend[PH_W-1:0];
  assign period_end = tick && (phase == LAST_PH);
  assign pwm_out    = run && (phase < duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      div_act  <= DIV_W'(DIV_RESET);
      duty_act <= '0;
    end else if (!run) begin
      phase    <= '0;
      div_act  <= div_pend;
      duty_act <= duty_lim;
    end else if (period_end) begin
      phase    <= '0;
      div_act  <= div_pend;
      duty_act <= duty_lim;
    end else if (tick) begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/bpwm_top.sv
module bpwm_top
  import bpwm_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned STEPS     = 100,
  parameter int unsigned DIV_RESET = 1999,
  parameter int unsigned RUN_CODE  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pwm_out
);
  localparam int unsigned PH_W = $clog2(STEPS);

  logic [BYTE_W-1:0] source_q;
  logic [DIV_W-1:0]  div_pend;
  logic [BYTE_W-1:0] duty_pend;
  logic [DIV_W-1:0]  div_act;
  logic [DIV_W-1:0]  pre_cnt;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   duty_act;
  logic              run;
  logic              tick;
  logic              period_end;

  assign wr_ready = 1'b1;
  assign run      = (source_q == BYTE_W'(RUN_CODE));

  bpwm_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_valid && wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .source_q (source_q),
    .div_pend (div_pend),
    .duty_pend(duty_pend)
  );

  bpwm_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .div_act(div_act),
    .pre_cnt(pre_cnt),
    .tick   (tick)
  );

  bpwm_phase #(
    .DIV_W(DIV_W), .STEPS(STEPS), .DIV_RESET(DIV_RESET), .PH_W(PH_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .div_pend  (div_pend),
    .duty_pend (duty_pend),
    .div_act   (div_act),
    .phase     (phase),
    .duty_act  (duty_act),
    .period_end(period_end),
    .pwm_out   (pwm_out)
  );
endmodule

// File: rtl/bpwm_chk.sv
module bpwm_chk #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned STEPS = 100,
  parameter int unsigned PH_W  = $clog2(STEPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             period_end,
  input logic [DIV_W-1:0] pre_cnt,
  input logic [DIV_W-1:0] div_act,
  input logic [PH_W-1:0]  phase,
  input logic [PH_W-1:0]  duty_act,
  input logic             pwm_out
);
  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pwm_out); // R2
  AST_DUTY_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    duty_act <= PH_W'(STEPS - 1)); // R4
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_W'(STEPS - 1)); // R3
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= div_act); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (phase == '0)); // R3
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_out); // R3
  AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !period_end) |=> ($stable(duty_act) && $stable(div_act))); // R6
endmodule

bind bpwm_top bpwm_chk #(.DIV_W(DIV_W), .STEPS(STEPS), .PH_W(PH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .period_end(period_end),
  .pre_cnt   (pre_cnt),
  .div_act   (div_act),
  .phase     (phase),
  .duty_act  (duty_act),
  .pwm_out   (pwm_out)
);

// File: tb/tb_bpwm_top.sv
`timescale 1ns/1ps
module tb_bpwm_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid;
  logic       wr_ready;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bpwm_top dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Samples len cycles starting at the current negedge; optional write at offset wr_at.
  task automatic measure(input int len, input int wr_at, input logic [1:0] a,
                         input logic [7:0] d, output int highs);
    highs = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm_out) highs++;
      if (i == wr_at) begin
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
      end else begin
        wr_valid = 1'b0;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic setup(input int div, input int duty);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'((div >> 8) & 255));
    wr(2'd2, 8'(div & 255));
    wr(2'd3, 8'(duty));
    wr(2'd0, 8'h01);
  endtask

  function automatic int expect_high(input int div, input int duty);
    return ((duty > 99) ? 99 : duty) * (div + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    check("R1 pwm in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pwm after reset", int'(pwm_out), 0);
    check("R8 ready", int'(wr_ready), 1);

    // R7: default divider 1999, duty 1 -> 2000 high cycles then low
    wr(2'd3, 8'd1);
    wr(2'd0, 8'h01);
    measure(2000, -1, 2'd0, 8'h00, h);
    check("R7 default divider high time", h, 2000);
    measure(500, -1, 2'd0, 8'h00, h);
    check("R7 low after high time", h, 0);

    // R3/R4/R9 sweep at divider 0
    for (int d = 0; d < 104; d++) begin
      int code;
      code = (d < 100) ? d : ((d == 100) ? 100 : ((d == 101) ? 128 : 255));
      if (d == 103) code = 99;
      setup(0, code);
      measure(100, -1, 2'd0, 8'h00, h);
      check((code > 99) ? "R4 clamp div0" : "R3 duty div0", h, expect_high(0, code));
    end

    // R3 sweep at divider 2 and 5
    for (int d = 0; d < 100; d += 9) begin
      setup(2, d);
      measure(300, -1, 2'd0, 8'h00, h);
      check("R3 duty div2", h, expect_high(2, d));
    end
    setup(5, 255);
    measure(600, -1, 2'd0, 8'h00, h);
    check("R4 clamp div5", h, expect_high(5, 255));
    measure(600, -1, 2'd0, 8'h00, h);
    check("R3 second period div5", h, expect_high(5, 255));

    // R6: duty written mid-period applies at next boundary
    setup(0, 30);
    measure(100, 40, 2'd3, 8'd70, h);
    check("R6 old duty holds", h, 30);
    measure(100, -1, 2'd0, 8'h00, h);
    check("R6 new duty at boundary", h, 70);

    // R5: high byte alone has no effect
    measure(100, 10, 2'd1, 8'h01, h);
    check("R5 hi only period", h, 70);
    measure(100, -1, 2'd0, 8'h00, h);
    check("R5 hi staged no effect", h, 70);
    measure(100, 10, 2'd1, 8'h00, h);
    check("R5 hi rewrite", h, 70);
    measure(100, 50, 2'd2, 8'h02, h);
    check("R6 divider holds in period", h, 70);
    measure(300, -1, 2'd0, 8'h00, h);
    check("R5 divider after lo write", h, expect_high(2, 70));

    // R2: other source codes stop the generator
    setup(0, 50);
    wr(2'd0, 8'h02);
    measure(300, -1, 2'd0, 8'h00, h);
    check("R2 source 0x02 stopped", h, 0);
    wr(2'd0, 8'hFF);
    measure(300, -1, 2'd0, 8'h00, h);
    check("R2 source 0xFF stopped", h, 0);
    wr(2'd0, 8'h01);
    measure(100, -1, 2'd0, 8'h00, h);
    check("R2 restart phase 0", h, 50);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule